// File: doc/BRIEF.md
# Output Virtual-Channel Credit and Ownership Tracker

This block sits on one output port of a router. It keeps one record for each virtual channel (VC) on that port. Each record holds the number of free buffer slots the downstream input side still has for that VC, and it says whether a packet currently owns the VC. Switch allocation reads a per-VC "credit available" flag before it grants a flit. The VC allocator reads a per-VC "free" flag before it hands a VC to a head flit.

Each flit sent through the switch costs its VC one credit. Credits come back from downstream on a separate channel, and each returned credit adds one. Ownership of a VC is kept by a small state machine per VC with two states, `VC_IDLE` and `VC_BUSY`. Transition `T_CLAIM` (`VC_IDLE`→`VC_BUSY`) happens on an allocator grant. Transition `T_RELEASE` (`VC_BUSY`→`VC_IDLE`) happens when the owning packet's tail flit is sent. Transition `T_HANDOFF` (`VC_BUSY`→`VC_BUSY`) is a release and a new grant in the same cycle; it exists only when the build-time parameter `SAME_CYCLE_REUSE` is set.

When `SAME_CYCLE_REUSE` is set, a VC whose tail departs is reported free in that same cycle, so the allocator can hand it on with no idle cycle. The cost is a longer combinational path from the send inputs to the free flags. When the parameter is clear, the VC is reported free only from the next cycle.

Top module: `ovc_tracker`

## Requirements
- R1: After reset every VC is free (`vc_free` all ones), every credit count equals `BUF_DEPTH` (default 4), every `credit_ok` bit is 1 and `credit_ovf` is 0.
- R2: A send on VC v (`send_valid`=1, `send_vc`=v) with no credit returned to v in that cycle lowers v's count by one in the following cycle. Counts are packed in `credit_cnt`, with VC v at bits [v*CW +: CW] and CW = clog2(`BUF_DEPTH`+1).
- R3: A credit returned to VC v raises v's count by one in the following cycle. If the count is already `BUF_DEPTH` and no send to v happens in that cycle, `credit_ovf` is 1 combinationally in that cycle and the count stays at `BUF_DEPTH`.
- R4: A send and a returned credit on the same VC in the same cycle leave the count unchanged and raise no overflow.
- R5: `credit_ok[v]` is 1 exactly when v's count is nonzero. A send to a VC whose count is zero leaves the count at zero.
- R6: An allocator grant (`alloc_valid`=1, `alloc_vc`=v) to a VC in `VC_IDLE` clears `vc_free[v]` from the following cycle.
- R7: A send with `send_tail`=1 on an owned VC returns it to `VC_IDLE`. With `SAME_CYCLE_REUSE`=0, `vc_free` stays 0 during that cycle and becomes 1 in the next.
- R8: With `SAME_CYCLE_REUSE`=1, `vc_free[v]` is 1 in the very cycle v's tail is sent. A grant to v in that cycle keeps v owned in the next cycle.
- R9: With `SAME_CYCLE_REUSE`=0, a grant to a VC that is in `VC_BUSY` is ignored, even in the cycle its tail departs: the VC is free in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | VC allocator grants a VC to a head flit |
| alloc_vc | input | VCW | VC being granted |
| send_valid | input | 1 | A flit leaves through the switch on this port |
| send_vc | input | VCW | VC of the departing flit |
| send_tail | input | 1 | Departing flit is a packet tail |
| credit_valid | input | 1 | One credit returns from downstream |
| credit_vc | input | VCW | VC the credit belongs to |
| vc_free | output | NUM_VCS | Per-VC free flag for the VC allocator |
| credit_ok | output | NUM_VCS | Per-VC nonzero-credit flag for switch allocation |
| credit_cnt | output | NUM_VCS*CW | Packed per-VC credit counts |
| credit_ovf | output | 1 | A returned credit would exceed the buffer depth |

## Verification
Two instances run side by side on the same stimulus, one with same-cycle reuse and one without. Comparing them at a tail-plus-grant cycle separates `T_HANDOFF` from a dropped grant, and separates the same-cycle free flag from the delayed one. Credit patterns cover a lone send, a lone return, a send and return together (at full and at partial count), and a drain to zero followed by an extra send. These patterns tell decrement, increment, cancellation and the saturation at each end apart. A return at full count with no matching send is the only pattern that should raise the overflow flag.

// File: rtl/ovc_pkg.sv
package ovc_pkg;

    typedef enum logic {
        VC_IDLE = 1'b0,
        VC_BUSY = 1'b1
    } vc_state_e;

endpackage

// File: rtl/ovc_credit_ctr.sv
module ovc_credit_ctr #(
    parameter int BUF_DEPTH = 4,
    localparam int CW = $clog2(BUF_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          give,
    output logic [CW-1:0] count,
    output logic          nonzero,
    output logic          overflow
);

    localparam logic [CW-1:0] FULL = CW'(BUF_DEPTH);

    logic          take_ok;
    logic [CW-1:0] count_nxt;

    assign take_ok  = take && (count != '0);
    assign nonzero  = (count != '0);
    assign overflow = give && !take_ok && (count == FULL);

    always_comb begin
        count_nxt = count;
        unique case ({give, take_ok})
            2'b10:   if (count != FULL) count_nxt = count + 1'b1;
            2'b01:   count_nxt = count - 1'b1;
            default: count_nxt = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count <= FULL;
        else        count <= count_nxt;
    end

    p_never_above_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL);

    p_decrement_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !give && count != '0) |=> (count == $past(count) - 1'b1));

    p_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && give && count != '0) |=> $stable(count));

    p_zero_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !give) |=> (count == '0));

endmodule

// File: rtl/ovc_own_fsm.sv
module ovc_own_fsm
    import ovc_pkg::*;
#(
    parameter bit SAME_CYCLE_REUSE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic claim,
    input  logic tail_out,
    output logic is_free
);

    vc_state_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= VC_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            VC_IDLE: if (claim) state_nxt = VC_BUSY;              // T_CLAIM
            VC_BUSY: begin
                if (tail_out) begin
                    if (SAME_CYCLE_REUSE && claim) state_nxt = VC_BUSY;  // T_HANDOFF
                    else                           state_nxt = VC_IDLE;  // T_RELEASE
                end
            end
            default: state_nxt = VC_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            VC_IDLE: is_free = 1'b1;
            VC_BUSY: is_free = SAME_CYCLE_REUSE && tail_out;
            default: is_free = 1'b0;
        endcase
    end

    p_claim_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == VC_IDLE && claim) |=> (state == VC_BUSY));

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == VC_BUSY && tail_out && !claim) |=> (state == VC_IDLE));

    p_handoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (SAME_CYCLE_REUSE && state == VC_BUSY && tail_out && claim) |=> (state == VC_BUSY));

    p_drop_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!SAME_CYCLE_REUSE && state == VC_BUSY && tail_out) |=> (state == VC_IDLE));

endmodule

// File: rtl/ovc_tracker.sv
module ovc_tracker #(
    parameter int NUM_VCS          = 4,
    parameter int BUF_DEPTH        = 4,
    parameter bit SAME_CYCLE_REUSE = 1'b0,
    localparam int VCW = (NUM_VCS > 1) ? $clog2(NUM_VCS) : 1,
    localparam int CW  = $clog2(BUF_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_valid,
    input  logic [VCW-1:0]        alloc_vc,
    input  logic                  send_valid,
    input  logic [VCW-1:0]        send_vc,
    input  logic                  send_tail,
    input  logic                  credit_valid,
    input  logic [VCW-1:0]        credit_vc,
    output logic [NUM_VCS-1:0]    vc_free,
    output logic [NUM_VCS-1:0]    credit_ok,
    output logic [NUM_VCS*CW-1:0] credit_cnt,
    output logic                  credit_ovf
);

    logic [NUM_VCS-1:0] grant_hit;
    logic [NUM_VCS-1:0] send_hit;
    logic [NUM_VCS-1:0] ret_hit;
    logic [NUM_VCS-1:0] ovf_vec;

    for (genvar v = 0; v < NUM_VCS; v++) begin : g_vc
        assign grant_hit[v] = alloc_valid  && (alloc_vc  == VCW'(v));
        assign send_hit[v]  = send_valid   && (send_vc   == VCW'(v));
        assign ret_hit[v]   = credit_valid && (credit_vc == VCW'(v));

        ovc_credit_ctr #(.BUF_DEPTH(BUF_DEPTH)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .take     (send_hit[v]),
            .give     (ret_hit[v]),
            .count    (credit_cnt[v*CW +: CW]),
            .nonzero  (credit_ok[v]),
            .overflow (ovf_vec[v])
        );

        ovc_own_fsm #(.SAME_CYCLE_REUSE(SAME_CYCLE_REUSE)) u_own (
            .clk      (clk),
            .rst_n    (rst_n),
            .claim    (grant_hit[v]),
            .tail_out (send_hit[v] && send_tail),
            .is_free  (vc_free[v])
        );
    end

    assign credit_ovf = |ovf_vec;

    p_ovf_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ovf_vec));

    p_ovf_needs_credit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        credit_ovf |-> credit_valid);

endmodule

// File: tb/tb_ovc_tracker.sv
module tb_ovc_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int NV  = 4;
    localparam int DEP = 4;
    localparam int VW  = 2;
    localparam int CW  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 1'b0;
    logic [VW-1:0] alloc_vc = '0;
    logic send_valid = 1'b0;
    logic [VW-1:0] send_vc = '0;
    logic send_tail = 1'b0;
    logic credit_valid = 1'b0;
    logic [VW-1:0] credit_vc = '0;

    logic [NV-1:0]    free_a, ok_a, free_b, ok_b;
    logic [NV*CW-1:0] cnt_a, cnt_b;
    logic             ovf_a, ovf_b;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovc_tracker #(.NUM_VCS(NV), .BUF_DEPTH(DEP), .SAME_CYCLE_REUSE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_vc(alloc_vc),
        .send_valid(send_valid), .send_vc(send_vc), .send_tail(send_tail),
        .credit_valid(credit_valid), .credit_vc(credit_vc),
        .vc_free(free_a), .credit_ok(ok_a), .credit_cnt(cnt_a), .credit_ovf(ovf_a)
    );

    ovc_tracker #(.NUM_VCS(NV), .BUF_DEPTH(DEP), .SAME_CYCLE_REUSE(1'b1)) dut_bp (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_vc(alloc_vc),
        .send_valid(send_valid), .send_vc(send_vc), .send_tail(send_tail),
        .credit_valid(credit_valid), .credit_vc(credit_vc),
        .vc_free(free_b), .credit_ok(ok_b), .credit_cnt(cnt_b), .credit_ovf(ovf_b)
    );

    function automatic int cnt_of(input logic [NV*CW-1:0] flat, input int v);
        return int'(flat[v*CW +: CW]);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        alloc_valid = 1'b0; send_valid = 1'b0; send_tail = 1'b0; credit_valid = 1'b0;
    endtask

    task automatic t_reset();
        for (int v = 0; v < NV; v++) chk("R1 count", cnt_of(cnt_a, v), DEP);
        chk("R1 free", int'(free_a), 15);
        chk("R1 ok", int'(ok_a), 15);
        chk("R1 ovf", int'(ovf_a), 0);
    endtask

    task automatic t_send_dec();
        send_valid = 1'b1; send_vc = 2'd0;
        tick(); idle_inputs(); #1;
        chk("R2 vc0 after send", cnt_of(cnt_a, 0), 3);
        chk("R2 vc1 untouched", cnt_of(cnt_a, 1), 4);
    endtask

    task automatic t_credit_ret();
        credit_valid = 1'b1; credit_vc = 2'd0; #1;
        chk("R3 no ovf below full", int'(ovf_a), 0);
        tick(); #1;
        chk("R3 vc0 after return", cnt_of(cnt_a, 0), 4);
        #1;
        chk("R3 ovf at full", int'(ovf_a), 1);
        tick(); idle_inputs(); #1;
        chk("R3 count saturates", cnt_of(cnt_a, 0), 4);
        chk("R3 ovf clears", int'(ovf_a), 0);
    endtask

    task automatic t_simul();
        send_valid = 1'b1; send_vc = 2'd1; credit_valid = 1'b1; credit_vc = 2'd1; #1;
        chk("R4 no ovf at full with send", int'(ovf_a), 0);
        tick(); idle_inputs(); #1;
        chk("R4 full unchanged", cnt_of(cnt_a, 1), 4);
        send_valid = 1'b1; send_vc = 2'd1;
        tick(); #1;
        credit_valid = 1'b1; credit_vc = 2'd1;
        tick(); idle_inputs(); #1;
        chk("R4 partial unchanged", cnt_of(cnt_a, 1), 3);
    endtask

    task automatic t_drain();
        send_valid = 1'b1; send_vc = 2'd2;
        for (int i = 0; i < DEP; i++) tick();
        #1;
        chk("R5 drained count", cnt_of(cnt_a, 2), 0);
        chk("R5 ok low at zero", int'(ok_a[2]), 0);
        tick(); idle_inputs(); #1;
        chk("R5 send at zero held", cnt_of(cnt_a, 2), 0);
        credit_valid = 1'b1; credit_vc = 2'd2;
        tick(); idle_inputs(); #1;
        chk("R5 ok after one credit", int'(ok_a[2]), 1);
        chk("R5 count one", cnt_of(cnt_a, 2), 1);
    endtask

    task automatic t_claim_release();
        alloc_valid = 1'b1; alloc_vc = 2'd3; #1;
        chk("R6 still free in grant cycle", int'(free_a[3]), 1);
        tick(); idle_inputs(); #1;
        chk("R6 owned after grant", int'(free_a[3]), 0);
        chk("R6 owned after grant bp", int'(free_b[3]), 0);
        send_valid = 1'b1; send_vc = 2'd3; send_tail = 1'b1; #1;
        chk("R7 not free in tail cycle", int'(free_a[3]), 0);
        chk("R8 free in tail cycle", int'(free_b[3]), 1);
        tick(); idle_inputs(); #1;
        chk("R7 free after tail", int'(free_a[3]), 1);
        chk("R7 bp free after tail", int'(free_b[3]), 1);
    endtask

    task automatic t_handoff();
        alloc_valid = 1'b1; alloc_vc = 2'd0;
        tick(); idle_inputs(); #1;
        alloc_valid = 1'b1; alloc_vc = 2'd0;
        send_valid = 1'b1; send_vc = 2'd0; send_tail = 1'b1; #1;
        chk("R9 not free in tail cycle", int'(free_a[0]), 0);
        chk("R8 free in handoff cycle", int'(free_b[0]), 1);
        tick(); idle_inputs(); #1;
        chk("R9 grant dropped, free", int'(free_a[0]), 1);
        chk("R8 handoff keeps owned", int'(free_b[0]), 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        t_reset();
        t_send_dec();
        t_credit_ret();
        t_simul();
        t_drain();
        t_claim_release();
        t_handoff();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule